// File: doc/BRIEF.md
# Serial Port FIFO Register Front End

This block sits between a simple word-addressed read/write bus and the bit-level engines of a serial port. Software writes outgoing bytes into a transmit queue and reads incoming bytes from a receive queue. Each queue is 64 entries deep. A control word holds the enable bits, the line format fields and the queue resets. A status word reports queue occupancy flags, the transmitter's shifting state and three sticky error flags. One interrupt line combines a receive-fill condition and a transmit-drain condition. Each condition has its own programmable threshold and its own enable bit.

The transmit queue feeds the serializer over a valid/ready handshake. The deserializer pushes received bytes over a second valid/ready handshake and reports parity and framing errors as one-cycle pulses. Three settings are plain stored control bits that software sets and then clears again: the queue resets, the error clear and the other control fields. None of them releases itself. The control fields for word length, parity, stop bits and two-wire mode are passed straight through to the serializer. The baud divisor is passed straight through to the baud generator.

Top module: `uart_regif`

## Requirements
- R1: After reset, the control, threshold and baud words read 0, the status word reads 0x0050_0000 (bits 20 and 22 set, meaning both queues are empty), and irq_o is low.
- R2: The word index is addr_i[4:2]. Index 0 is the transmit data port and index 1 is the receive data port. Index 2 is control, which keeps only bits 12, 13, 15, 16 to 24, 27 and 28. Index 3 is status and is read-only. Index 4 is the threshold word and keeps bits 15:0. Index 5 is the baud word and keeps bits 24:0. All other bits and indices read 0. two_wire_o follows control bit 15, line_cfg_o follows control bits 21:16, and baud_cfg_o follows the baud word.
- R3: A write to index 0 queues wdata_i[7:0]. tx_valid_o is high when control bit 12 is set and the queue is not empty. Bytes leave in write order, one on each cycle in which tx_valid_o and tx_ready_i are both high. Status bit 21 means the queue holds 64 entries and bit 22 means it is empty.
- R4: A write to index 0 while the transmit queue holds 64 entries drops the byte and sets sticky status bit 18.
- R5: rx_ready_o is high when control bit 13 is set, control bit 23 is clear and the receive queue is not full. A byte is queued on each cycle with rx_valid_i and rx_ready_o both high. A read of index 1 returns the oldest byte in bits 7:0 and removes it. Status bit 20 means the receive queue is empty.
- R6: A read of index 1 while the receive queue is empty returns 0 and leaves the queue unchanged.
- R7: A pulse on rx_par_err_i sets sticky status bit 16, and a pulse on rx_frm_err_i sets sticky status bit 17.
- R8: While control bit 24 is set, status bits 16 to 18 are cleared and stay 0. After the bit is cleared they stay 0 until a new error occurs.
- R9: While control bit 22 is set, the transmit queue is held empty and writes to it are dropped without an error. While control bit 23 is set, the receive queue is held empty.
- R10: The receive part of irq_o is active when control bit 27 is set and the receive count is at least threshold bits 7:0.
- R11: The transmit part of irq_o is active when control bit 28 is set and the transmit count is at most threshold bits 15:8.
- R12: Status bit 25 reflects tx_busy_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 5 | Byte address of the word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| tx_data_o | output | 8 | Byte offered to the serializer |
| tx_valid_o | output | 1 | Transmit byte available |
| tx_ready_i | input | 1 | Serializer takes the byte |
| tx_busy_i | input | 1 | Serializer is shifting a character |
| rx_data_i | input | 8 | Byte from the deserializer |
| rx_valid_i | input | 1 | Received byte available |
| rx_ready_o | output | 1 | Receive queue accepts a byte |
| rx_par_err_i | input | 1 | Parity error pulse |
| rx_frm_err_i | input | 1 | Framing error pulse |
| two_wire_o | output | 1 | Two-wire mode (no flow control) |
| line_cfg_o | output | 6 | Stop bits, parity and word length fields |
| baud_cfg_o | output | 25 | Baud divisor word |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check several properties on every cycle. A stalled transmit byte stays offered and unchanged. A held queue reset empties the queue. A push into a full queue leaves its count alone. A write while full raises the overflow flag. The error flags never drop except under the clear bit. An empty receive read returns 0. Some properties can only be shown by the bench's scenarios, comparing against a queue-based model: byte ordering through both queues, the exact threshold edges of the interrupt, the masking of control bits, and the fact that a dropped byte never appears at the serializer.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;

  localparam logic [2:0] IDX_TXD  = 3'd0;
  localparam logic [2:0] IDX_RXD  = 3'd1;
  localparam logic [2:0] IDX_CTRL = 3'd2;
  localparam logic [2:0] IDX_STAT = 3'd3;
  localparam logic [2:0] IDX_THR  = 3'd4;
  localparam logic [2:0] IDX_BAUD = 3'd5;

  localparam int unsigned C_TX_EN   = 12;
  localparam int unsigned C_RX_EN   = 13;
  localparam int unsigned C_TWO_W   = 15;
  localparam int unsigned C_LINE_LO = 16;
  localparam int unsigned C_LINE_HI = 21;
  localparam int unsigned C_TX_RST  = 22;
  localparam int unsigned C_RX_RST  = 23;
  localparam int unsigned C_CLR_ERR = 24;
  localparam int unsigned C_RX_IE   = 27;
  localparam int unsigned C_TX_IE   = 28;
  localparam logic [WORD_W-1:0] CTRL_MASK = 32'h19FF_B000;

  localparam int unsigned S_PAR     = 16;
  localparam int unsigned S_FRM     = 17;
  localparam int unsigned S_OVF     = 18;
  localparam int unsigned S_RX_EMP  = 20;
  localparam int unsigned S_TX_FULL = 21;
  localparam int unsigned S_TX_EMP  = 22;
  localparam int unsigned S_BUSY    = 25;

  localparam int unsigned THR_W  = 8;
  localparam int unsigned BAUD_W = 25;
endpackage

// File: rtl/uart_regif_fifo.sv
module uart_regif_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic          do_push, do_pop;

  assign empty_o = (count_o == '0);
  assign full_o  = (count_o == CW'(DEPTH));
  assign do_push = push_i && !full_o && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;
  assign rdata_o = mem_q[rd_ptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_o  <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_o  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH)); // R3
  AST_FIFO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o); // R9
  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !clr_i) |=> (count_o == $past(count_o))); // R4
endmodule

// File: rtl/uart_regif_err.sv
module uart_regif_err #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flags_o <= '0;
    else if (clr_i) flags_o <= '0;
    else            flags_o <= flags_o | set_i;
  end

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o))); // R7
  AST_ERR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (flags_o == '0)); // R8
endmodule

// File: rtl/uart_regif_irq.sv
module uart_regif_irq #(
  parameter int unsigned CW    = 7,
  parameter int unsigned THR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CW-1:0]    rx_cnt_i,
  input  logic [CW-1:0]    tx_cnt_i,
  input  logic [THR_W-1:0] rx_thr_i,
  input  logic [THR_W-1:0] tx_thr_i,
  input  logic             rx_ie_i,
  input  logic             tx_ie_i,
  output logic             irq_o
);
  logic rx_hit, tx_hit;

  assign rx_hit = (32'(rx_cnt_i) >= 32'(rx_thr_i));
  assign tx_hit = (32'(tx_cnt_i) <= 32'(tx_thr_i));
  assign irq_o  = (rx_ie_i && rx_hit) || (tx_ie_i && tx_hit);

  AST_IRQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rx_ie_i || tx_ie_i)); // R10
  AST_IRQ_TX_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ie_i && tx_cnt_i == '0) |-> irq_o); // R11
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int unsigned ADDR_W     = 5,
  localparam int unsigned CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output logic [WORD_W-1:0]   rdata_o,
  output logic [BYTE_W-1:0]   tx_data_o,
  output logic                tx_valid_o,
  input  logic                tx_ready_i,
  input  logic                tx_busy_i,
  input  logic [BYTE_W-1:0]   rx_data_i,
  input  logic                rx_valid_i,
  output logic                rx_ready_o,
  input  logic                rx_par_err_i,
  input  logic                rx_frm_err_i,
  output logic                two_wire_o,
  output logic [5:0]          line_cfg_o,
  output logic [BAUD_W-1:0]   baud_cfg_o,
  output logic                irq_o
);
  logic [2:0]          wsel;
  logic                wr_txd, wr_ctrl, wr_thr, wr_baud, rd_rxd;
  logic [WORD_W-1:0]   ctrl_q;
  logic [2*THR_W-1:0]  thr_q;
  logic [BAUD_W-1:0]   baud_q;
  logic                tx_rst, rx_rst, clr_err, ovf_set;
  logic [BYTE_W-1:0]   rx_head;
  logic [CW-1:0]       tx_cnt, rx_cnt;
  logic                tx_empty, tx_full, rx_empty, rx_full;
  logic [2:0]          err_q;
  logic [WORD_W-1:0]   status;
  logic                unused_addr;

  assign wsel        = addr_i[4:2];
  assign unused_addr = ^addr_i[1:0];
  assign wr_txd  = req_i && we_i  && (wsel == IDX_TXD);
  assign wr_ctrl = req_i && we_i  && (wsel == IDX_CTRL);
  assign wr_thr  = req_i && we_i  && (wsel == IDX_THR);
  assign wr_baud = req_i && we_i  && (wsel == IDX_BAUD);
  assign rd_rxd  = req_i && !we_i && (wsel == IDX_RXD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      thr_q  <= '0;
      baud_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i & CTRL_MASK;
      if (wr_thr)  thr_q  <= wdata_i[2*THR_W-1:0];
      if (wr_baud) baud_q <= wdata_i[BAUD_W-1:0];
    end
  end

  assign tx_rst  = ctrl_q[C_TX_RST];
  assign rx_rst  = ctrl_q[C_RX_RST];
  assign clr_err = ctrl_q[C_CLR_ERR];

  assign two_wire_o = ctrl_q[C_TWO_W];
  assign line_cfg_o = ctrl_q[C_LINE_HI:C_LINE_LO];
  assign baud_cfg_o = baud_q;

  // transmit path
  assign tx_valid_o = ctrl_q[C_TX_EN] && !tx_empty && !tx_rst;
  assign ovf_set    = wr_txd && tx_full && !tx_rst;

  uart_regif_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tx_rst),
    .push_i  (wr_txd),
    .pop_i   (tx_valid_o && tx_ready_i),
    .wdata_i (wdata_i[BYTE_W-1:0]),
    .rdata_o (tx_data_o),
    .count_o (tx_cnt),
    .empty_o (tx_empty),
    .full_o  (tx_full)
  );

  // receive path
  assign rx_ready_o = ctrl_q[C_RX_EN] && !rx_full && !rx_rst;

  uart_regif_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (rx_rst),
    .push_i  (rx_valid_i && rx_ready_o),
    .pop_i   (rd_rxd),
    .wdata_i (rx_data_i),
    .rdata_o (rx_head),
    .count_o (rx_cnt),
    .empty_o (rx_empty),
    .full_o  (rx_full)
  );

  uart_regif_err #(.N(3)) u_err (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_err),
    .set_i   ({ovf_set, rx_frm_err_i, rx_par_err_i}),
    .flags_o (err_q)
  );

  uart_regif_irq #(.CW(CW), .THR_W(THR_W)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rx_cnt_i (rx_cnt),
    .tx_cnt_i (tx_cnt),
    .rx_thr_i (thr_q[THR_W-1:0]),
    .tx_thr_i (thr_q[2*THR_W-1:THR_W]),
    .rx_ie_i  (ctrl_q[C_RX_IE]),
    .tx_ie_i  (ctrl_q[C_TX_IE]),
    .irq_o    (irq_o)
  );

  always_comb begin
    status            = '0;
    status[S_PAR]     = err_q[0];
    status[S_FRM]     = err_q[1];
    status[S_OVF]     = err_q[2];
    status[S_RX_EMP]  = rx_empty;
    status[S_TX_FULL] = tx_full;
    status[S_TX_EMP]  = tx_empty;
    status[S_BUSY]    = tx_busy_i;
  end

  always_comb begin
    rdata_o = '0;
    case (wsel)
      IDX_RXD:  rdata_o = rx_empty ? '0 : WORD_W'(rx_head);
      IDX_CTRL: rdata_o = ctrl_q;
      IDX_STAT: rdata_o = status;
      IDX_THR:  rdata_o = WORD_W'(thr_q);
      IDX_BAUD: rdata_o = WORD_W'(baud_q);
      default:  rdata_o = '0;
    endcase
  end

  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !wr_ctrl) |=> (tx_valid_o && $stable(tx_data_o))); // R3
  AST_OVF_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_txd && tx_full && !tx_rst && !clr_err) |=> status[S_OVF]); // R4
  AST_RX_EMPTY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rxd && status[S_RX_EMP]) |-> (rdata_o == '0)); // R6
  AST_RX_NO_PUSH_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full || rx_rst) |-> !rx_ready_o); // R5
endmodule

// File: tb/uart_regif_tb_top.sv
module uart_regif_tb_top;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req = 0, we = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_ready = 0, tx_busy = 0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 0, rx_ready, par_err = 0, frm_err = 0;
  logic        two_wire, irq;
  logic [5:0]  line_cfg;
  logic [24:0] baud_cfg;

  uart_regif dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .tx_ready_i(tx_ready), .tx_busy_i(tx_busy), .rx_data_i(rx_data),
    .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .rx_par_err_i(par_err),
    .rx_frm_err_i(frm_err), .two_wire_o(two_wire), .line_cfg_o(line_cfg),
    .baud_cfg_o(baud_cfg), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [31:0] m_ctrl, m_thr, m_baud;
  bit m_par, m_frm, m_ovf;
  byte unsigned txq[$], rxq[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [4:0] a);
    logic [31:0] s;
    case (a[4:2])
      3'd1: return (rxq.size() > 0) ? 32'(rxq[0]) : 32'h0;
      3'd2: return m_ctrl;
      3'd3: begin
        s = '0;
        s[16] = m_par; s[17] = m_frm; s[18] = m_ovf;
        s[20] = (rxq.size() == 0);
        s[21] = (txq.size() == DEPTH);
        s[22] = (txq.size() == 0);
        s[25] = tx_busy;
        return s;
      end
      3'd4: return m_thr;
      3'd5: return m_baud;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit exp_txv();
    return m_ctrl[12] && !m_ctrl[22] && txq.size() > 0;
  endfunction
  function automatic bit exp_rxr();
    return m_ctrl[13] && !m_ctrl[23] && rxq.size() < DEPTH;
  endfunction
  function automatic bit exp_irq();
    return (m_ctrl[27] && rxq.size() >= int'(m_thr[7:0])) ||
           (m_ctrl[28] && txq.size() <= int'(m_thr[15:8]));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_thr = 0; m_baud = 0;
      m_par = 0; m_frm = 0; m_ovf = 0;
      txq.delete(); rxq.delete();
    end else begin
      automatic bit txr = m_ctrl[22], rxr = m_ctrl[23], clr = m_ctrl[24];
      automatic bit txv = exp_txv(), rxrdy = exp_rxr();
      automatic int txn = txq.size();
      automatic int rxn = rxq.size();
      automatic bit ovf = 0;
      if (txv && tx_ready) void'(txq.pop_front());
      if (req && we && addr[4:2] == 3'd0 && !txr) begin
        if (txn == DEPTH) ovf = 1;
        else txq.push_back(wdata[7:0]);
      end
      if (rx_valid && rxrdy) rxq.push_back(rx_data);
      if (req && !we && addr[4:2] == 3'd1 && rxn > 0 && !rxr) void'(rxq.pop_front());
      if (clr) begin m_par = 0; m_frm = 0; m_ovf = 0; end
      else begin m_par |= par_err; m_frm |= frm_err; m_ovf |= ovf; end
      if (txr) txq.delete();
      if (rxr) rxq.delete();
      if (req && we) begin
        if (addr[4:2] == 3'd2) m_ctrl = wdata & 32'h19FF_B000;
        if (addr[4:2] == 3'd4) m_thr  = {16'h0, wdata[15:0]};
        if (addr[4:2] == 3'd5) m_baud = {7'h0, wdata[24:0]};
      end
    end
  end

  // per-cycle comparison of state-driven outputs
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(tx_valid == exp_txv(), "R3 tx_valid", 32'(tx_valid), 32'(exp_txv()));
      if (exp_txv()) chk(tx_data == txq[0], "R3 tx_data order", 32'(tx_data), 32'(txq[0]));
      chk(rx_ready == exp_rxr(), "R5 R9 rx_ready", 32'(rx_ready), 32'(exp_rxr()));
      chk(irq == exp_irq(), "R10 R11 irq", 32'(irq), 32'(exp_irq()));
      chk(two_wire == m_ctrl[15] && line_cfg == m_ctrl[21:16] && baud_cfg == m_baud[24:0],
          "R2 passthrough", {two_wire, line_cfg, baud_cfg}, {m_ctrl[15], m_ctrl[21:16], m_baud[24:0]});
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk); req = 1; we = 0; addr = a;
    #1; e = exp_rd(a);
    chk(rdata == e, tag, rdata, e);
    @(negedge clk); req = 0;
  endtask

  task automatic rd_lit(input logic [4:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1; chk(rdata == e, tag, rdata, e);
    @(negedge clk); req = 0;
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 run did not finish actual=hung expected=done");
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1;
    // R1 reset state
    rd_lit(5'h08, 32'h0, "R1 ctrl reset");
    rd_lit(5'h0C, 32'h0050_0000, "R1 status reset");
    rd_lit(5'h10, 32'h0, "R1 thr reset");
    rd_lit(5'h14, 32'h0, "R1 baud reset");
    chk(irq == 1'b0, "R1 irq reset", 32'(irq), 0);
    // R2 masking
    wr(5'h08, 32'hFFFF_FFFF); rd_lit(5'h08, 32'h19FF_B000, "R2 ctrl mask");
    wr(5'h10, 32'hFFFF_FFFF); rd_lit(5'h10, 32'h0000_FFFF, "R2 thr mask");
    wr(5'h14, 32'hFFFF_FFFF); rd_lit(5'h14, 32'h01FF_FFFF, "R2 baud mask");
    rd_lit(5'h18, 32'h0, "R2 unmapped index");
    rd_lit(5'h00, 32'h0, "R2 tx port reads 0");
    wr(5'h08, 32'h0002_8000); wr(5'h10, 0); wr(5'h14, 32'h123);
    wr(5'h08, 0);
    // R3 transmit order
    wr(5'h08, 32'h1 << 12);
    wr(5'h00, 32'hA1); wr(5'h00, 32'hFFFF_FFB2); wr(5'h00, 32'hC3);
    rd(5'h0C, "R3 status not empty");
    tx_ready = 1; idle(5); tx_ready = 0;
    rd(5'h0C, "R3 status empty after drain");
    // R4 overflow
    wr(5'h08, 0);
    for (int i = 0; i < DEPTH; i++) wr(5'h00, 32'(i + 1));
    rd(5'h0C, "R3 status full");
    wr(5'h00, 32'hEE);
    rd(5'h0C, "R4 overflow flag");
    wr(5'h08, 32'h1 << 12); tx_ready = 1; idle(DEPTH + 4); tx_ready = 0;
    rd(5'h0C, "R4 flag sticky after drain");
    // R8 clear
    wr(5'h08, 32'h1 << 24); rd(5'h0C, "R8 cleared while held");
    wr(5'h08, 0); rd(5'h0C, "R8 stays clear");
    // R9 transmit reset
    wr(5'h00, 1); wr(5'h00, 2); wr(5'h00, 3);
    wr(5'h08, 32'h1 << 22); wr(5'h00, 32'h55);
    rd(5'h0C, "R9 tx held empty, no overflow");
    wr(5'h08, 32'h1 << 12); idle(2);
    rd(5'h0C, "R9 tx empty after release");
    // R9 receive reset
    wr(5'h08, 32'h1 << 13); rx_send(8'h11); rx_send(8'h22);
    wr(5'h08, (32'h1 << 13) | (32'h1 << 23));
    rd(5'h0C, "R9 rx held empty");
    rd(5'h04, "R9 rx read while reset");
    // R5 R6 receive
    wr(5'h08, 32'h1 << 13);
    rx_send(8'h5A); rx_send(8'h00); rx_send(8'hFF);
    rd(5'h0C, "R5 rx not empty");
    rd(5'h04, "R5 first byte"); rd(5'h04, "R5 second byte"); rd(5'h04, "R5 third byte");
    rd_lit(5'h04, 32'h0, "R6 empty read 0");
    rx_send(8'h77);
    rd(5'h04, "R6 pointers unchanged");
    // R7 line errors
    @(negedge clk); par_err = 1; @(negedge clk); par_err = 0;
    rd(5'h0C, "R7 parity flag");
    @(negedge clk); frm_err = 1; @(negedge clk); frm_err = 0;
    rd(5'h0C, "R7 frame flag");
    wr(5'h08, (32'h1 << 13) | (32'h1 << 24));
    @(negedge clk); par_err = 1; @(negedge clk); par_err = 0;
    rd(5'h0C, "R8 error ignored while clear held");
    wr(5'h08, 32'h1 << 13); rd(5'h0C, "R8 clear after release");
    // R10 receive threshold
    wr(5'h10, 3); wr(5'h08, (32'h1 << 13) | (32'h1 << 27));
    rx_send(8'h01); rx_send(8'h02); rx_send(8'h03); idle(2);
    chk(irq == 1'b1, "R10 irq at threshold", 32'(irq), 1);
    rd(5'h04, "R10 pop below threshold");
    chk(irq == 1'b0, "R10 irq below threshold", 32'(irq), 0);
    rd(5'h04, "R10 pop"); rd(5'h04, "R10 pop");
    // R11 transmit threshold
    wr(5'h10, 32'h2 << 8); wr(5'h08, 32'h1 << 28);
    chk(irq == 1'b1, "R11 irq tx empty", 32'(irq), 1);
    wr(5'h00, 9); wr(5'h00, 8);
    chk(irq == 1'b1, "R11 irq at threshold", 32'(irq), 1);
    wr(5'h00, 7);
    chk(irq == 1'b0, "R11 irq above threshold", 32'(irq), 0);
    wr(5'h08, (32'h1 << 28) | (32'h1 << 22)); wr(5'h08, 0);
    // R12 busy
    tx_busy = 1; rd(5'h0C, "R12 busy high");
    tx_busy = 0; rd(5'h0C, "R12 busy low");
    // R5 receive full
    wr(5'h08, 32'h1 << 13);
    for (int i = 0; i < DEPTH + 2; i++) rx_send(8'(i));
    chk(rx_ready == 1'b0, "R5 rx full not ready", 32'(rx_ready), 0);
    rd(5'h04, "R5 oldest after full");
    wr(5'h08, 32'h1 << 23); wr(5'h08, 0);
    rd(5'h0C, "R9 rx empty after reset");
    idle(2);
    summary();
  end
endmodule